// File: doc/BRIEF.md
# Four-Mode Operand Address Resolver

This block turns the two operand fields of a 16-bit instruction into values and write locations. Each operand names one of four modes: a register, a literal, an absolute RAM address, or an indirect RAM address. An indirect address is the sum of a dedicated reference register and an offset carried in the instruction. The block reads one register-file port, issues RAM reads over a request/acknowledge handshake, and reports the resolved source and destination values together with up to two writeback targets.

The caller presents an opcode class, two mode fields and two 16-bit fields with `start` while `ready` is high. Before any operand is read, the block checks the combination against the rules of the opcode class. An illegal combination finishes at once with `res_illegal`. It issues no memory request and reports no target. A legal one walks a state machine. The states are IDLE (waiting for `start`), SRC (resolve source), SRC_WAIT (source RAM read pending), DST (resolve destination), DST_WAIT (destination RAM read pending), FIN (result valid) and BAD (illegal result). The transitions are as follows:
- IDLE goes to BAD on an illegal start, to FIN on a start of the no-operand class, and to SRC on any other start.
- SRC goes to SRC_WAIT for a RAM mode. Otherwise it goes to DST if the class reads a destination, or to FIN if it does not.
- SRC_WAIT leaves on acknowledge, to DST or FIN by the same rule.
- DST goes to DST_WAIT for a RAM mode, or to FIN otherwise.
- DST_WAIT goes to FIN on acknowledge.
- FIN and BAD both return to IDLE after one cycle.

Top module: `operand_resolver`

## Requirements
- R1: After reset `ready` is 1, `res_valid` is 0 and `mem_req` is 0.
- R2: Mode 2'b00 (register) yields the register-file word at index field[3:0] and a target of kind 2'b01 with address equal to that index. Mode 2'b01 (literal) yields the field itself.
- R3: Mode 2'b10 (absolute) issues a RAM read at the field value. The operand value is the returned word, and `res_valid` stays 0 while `mem_req` is 1.
- R4: Mode 2'b11 (indirect) reads at register 15 plus the field, modulo 2^16, and a target of kind 2'b10 carries that address.
- R5: Class 3'd0 (two-operand) accepts any source mode but treats a literal destination as illegal. Its target wb0 is the destination location and wb1 is none (2'b00).
- R6: Class 3'd1 (swap) treats a literal in either operand as illegal. wb0 is the destination location and wb1 is the source location.
- R7: Class 3'd2 (unary modify) uses the source fields only and treats a literal as illegal. wb0 is the operand location.
- R8: Class 3'd3 (flow, push, transmit) accepts all four source modes, ignores the destination fields and produces no target.
- R9: An illegal combination raises `res_valid` with `res_illegal` in the cycle after `start` is accepted, issues no RAM request, and reports both targets as none.
- R10: When both operands need RAM, the source read comes before the destination read. `mem_req` and `mem_addr` hold steady until `mem_ack`.
- R11: Class 3'd4 (no operands) completes in the cycle after `start` with no target and no RAM access. Classes 3'd5 to 3'd7 are illegal.
- R12: `res_valid` is a one-cycle pulse, after which `ready` returns to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Operand set presented, taken when ready |
| op_class | input | 3 | Opcode class |
| src_mode | input | 2 | Source operand mode |
| dst_mode | input | 2 | Destination operand mode |
| src_field | input | 16 | Source register index, literal, address or offset |
| dst_field | input | 16 | Destination register index, address or offset |
| ready | output | 1 | Idle and able to take a start |
| rf_raddr | output | 4 | Register-file read index |
| rf_rdata | input | 16 | Register-file read data (combinational) |
| mem_req | output | 1 | RAM read request |
| mem_addr | output | 16 | RAM read address |
| mem_ack | input | 1 | RAM read data valid |
| mem_rdata | input | 16 | RAM read data |
| res_valid | output | 1 | Result pulse |
| res_illegal | output | 1 | Operand combination rejected |
| src_value | output | 16 | Resolved source value |
| dst_value | output | 16 | Resolved destination value |
| wb0_kind | output | 2 | First target: 00 none, 01 register, 10 RAM |
| wb0_addr | output | 16 | First target index or address |
| wb1_kind | output | 2 | Second target (swap source) |
| wb1_addr | output | 16 | Second target index or address |

## Verification
The hardest situation to reach is two RAM reads in a row, each held off by acknowledge latency, where both addresses are indirect and the sum wraps past 16 bits. To reach it, the bench sets the reference register near the top of the address space and uses memory-mode source and destination fields. Its memory model delays each acknowledge by a programmable number of cycles and logs the order of the addresses it serves. The illegal paths are reached by pairing literal modes with RAM-mode partners, so that a stray request would be visible.

// File: rtl/opr_pkg.sv
package opr_pkg;

    typedef enum logic [1:0] {
        MD_REG = 2'b00,
        MD_LIT = 2'b01,
        MD_ABS = 2'b10,
        MD_IND = 2'b11
    } opr_mode_e;

    typedef enum logic [2:0] {
        CL_BIN  = 3'd0,
        CL_SWAP = 3'd1,
        CL_MOD  = 3'd2,
        CL_FLOW = 3'd3,
        CL_NONE = 3'd4
    } opr_class_e;

    typedef enum logic [1:0] {
        LOC_NONE = 2'b00,
        LOC_REG  = 2'b01,
        LOC_MEM  = 2'b10
    } opr_loc_e;

    typedef enum logic [2:0] {
        S_IDLE,
        S_SRC,
        S_SRC_WAIT,
        S_DST,
        S_DST_WAIT,
        S_FIN,
        S_BAD
    } opr_state_e;

endpackage

// File: rtl/opr_legality.sv
module opr_legality
    import opr_pkg::*;
(
    input  logic [2:0] cls,
    input  logic [1:0] smode,
    input  logic [1:0] dmode,
    output logic       legal,
    output logic       no_ops,
    output logic       reads_dst
);
    logic s_lit;
    logic d_lit;

    assign s_lit = (smode == MD_LIT);
    assign d_lit = (dmode == MD_LIT);

    always_comb begin
        legal     = 1'b0;
        no_ops    = 1'b0;
        reads_dst = 1'b0;
        unique case (cls)
            CL_BIN: begin
                legal     = !d_lit;
                reads_dst = 1'b1;
            end
            CL_SWAP: begin
                legal     = !s_lit && !d_lit;
                reads_dst = 1'b1;
            end
            CL_MOD:  legal = !s_lit;
            CL_FLOW: legal = 1'b1;
            CL_NONE: begin
                legal  = 1'b1;
                no_ops = 1'b1;
            end
            default: legal = 1'b0;
        endcase
    end
endmodule

// File: rtl/opr_ea.sv
module opr_ea
    import opr_pkg::*;
#(
    parameter int W = 16
) (
    input  logic [1:0]   mode,
    input  logic [W-1:0] field,
    input  logic [W-1:0] base,
    output logic         is_mem,
    output logic [W-1:0] addr
);
    always_comb begin
        is_mem = mode[1];
        if (mode == MD_IND) addr = base + field;
        else                addr = field;
    end
endmodule

// File: rtl/opr_ctrl.sv
module opr_ctrl
    import opr_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic       legal,
    input  logic       no_ops,
    input  logic       src_mem,
    input  logic       dst_mem,
    input  logic       reads_dst_q,
    input  logic       mem_ack,
    output opr_state_e state
);
    opr_state_e nxt;

    always_ff @(posedge clk) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= nxt;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            S_IDLE: begin
                if (start) begin
                    if (!legal)      nxt = S_BAD;
                    else if (no_ops) nxt = S_FIN;
                    else             nxt = S_SRC;
                end
            end
            S_SRC: begin
                if (src_mem)          nxt = S_SRC_WAIT;
                else if (reads_dst_q) nxt = S_DST;
                else                  nxt = S_FIN;
            end
            S_SRC_WAIT: begin
                if (mem_ack) nxt = reads_dst_q ? S_DST : S_FIN;
            end
            S_DST: nxt = dst_mem ? S_DST_WAIT : S_FIN;
            S_DST_WAIT: begin
                if (mem_ack) nxt = S_FIN;
            end
            S_FIN:   nxt = S_IDLE;
            S_BAD:   nxt = S_IDLE;
            default: nxt = S_IDLE;
        endcase
    end
endmodule

// File: rtl/operand_resolver.sv
module operand_resolver
    import opr_pkg::*;
#(
    parameter int DW      = 16,
    parameter int NREGS   = 16,
    parameter int REF_IDX = 15,
    localparam int RAW    = $clog2(NREGS)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           start,
    input  logic [2:0]     op_class,
    input  logic [1:0]     src_mode,
    input  logic [1:0]     dst_mode,
    input  logic [DW-1:0]  src_field,
    input  logic [DW-1:0]  dst_field,
    output logic           ready,
    output logic [RAW-1:0] rf_raddr,
    input  logic [DW-1:0]  rf_rdata,
    output logic           mem_req,
    output logic [DW-1:0]  mem_addr,
    input  logic           mem_ack,
    input  logic [DW-1:0]  mem_rdata,
    output logic           res_valid,
    output logic           res_illegal,
    output logic [DW-1:0]  src_value,
    output logic [DW-1:0]  dst_value,
    output logic [1:0]     wb0_kind,
    output logic [DW-1:0]  wb0_addr,
    output logic [1:0]     wb1_kind,
    output logic [DW-1:0]  wb1_addr
);
    opr_state_e    state;
    logic          legal, no_ops, reads_dst;
    logic [2:0]    cls_q;
    logic [1:0]    sm_q, dm_q;
    logic [DW-1:0] sf_q, df_q;
    logic          reads_dst_q;
    logic [DW-1:0] sval_q, dval_q;
    logic [1:0]    sloc_q, dloc_q;
    logic [DW-1:0] saddr_q, daddr_q;
    logic [1:0]    cur_mode;
    logic [DW-1:0] cur_field;
    logic          ea_mem;
    logic [DW-1:0] ea_addr;

    opr_legality u_leg (
        .cls       (op_class),
        .smode     (src_mode),
        .dmode     (dst_mode),
        .legal     (legal),
        .no_ops    (no_ops),
        .reads_dst (reads_dst)
    );

    opr_ctrl u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .start       (start),
        .legal       (legal),
        .no_ops      (no_ops),
        .src_mem     (sm_q[1]),
        .dst_mem     (dm_q[1]),
        .reads_dst_q (reads_dst_q),
        .mem_ack     (mem_ack),
        .state       (state)
    );

    assign cur_mode  = (state == S_DST) ? dm_q : sm_q;
    assign cur_field = (state == S_DST) ? df_q : sf_q;

    opr_ea #(.W(DW)) u_ea (
        .mode   (cur_mode),
        .field  (cur_field),
        .base   (rf_rdata),
        .is_mem (ea_mem),
        .addr   (ea_addr)
    );

    // register index of the operand being resolved, or the reference register
    always_comb begin
        rf_raddr = RAW'(REF_IDX);
        if (state == S_SRC && sm_q == MD_REG) rf_raddr = sf_q[RAW-1:0];
        if (state == S_DST && dm_q == MD_REG) rf_raddr = df_q[RAW-1:0];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cls_q       <= '0;
            sm_q        <= '0;
            dm_q        <= '0;
            sf_q        <= '0;
            df_q        <= '0;
            reads_dst_q <= 1'b0;
            sval_q      <= '0;
            dval_q      <= '0;
            sloc_q      <= LOC_NONE;
            dloc_q      <= LOC_NONE;
            saddr_q     <= '0;
            daddr_q     <= '0;
        end else begin
            unique case (state)
                S_IDLE: begin
                    if (start) begin
                        cls_q       <= op_class;
                        sm_q        <= src_mode;
                        dm_q        <= dst_mode;
                        sf_q        <= src_field;
                        df_q        <= dst_field;
                        reads_dst_q <= reads_dst;
                        sval_q      <= '0;
                        dval_q      <= '0;
                        sloc_q      <= LOC_NONE;
                        dloc_q      <= LOC_NONE;
                        saddr_q     <= '0;
                        daddr_q     <= '0;
                    end
                end
                S_SRC: begin
                    if (ea_mem) begin
                        sloc_q  <= LOC_MEM;
                        saddr_q <= ea_addr;
                    end else if (sm_q == MD_REG) begin
                        sval_q  <= rf_rdata;
                        sloc_q  <= LOC_REG;
                        saddr_q <= DW'(sf_q[RAW-1:0]);
                    end else begin
                        sval_q  <= sf_q;
                    end
                end
                S_SRC_WAIT: begin
                    if (mem_ack) sval_q <= mem_rdata;
                end
                S_DST: begin
                    if (ea_mem) begin
                        dloc_q  <= LOC_MEM;
                        daddr_q <= ea_addr;
                    end else if (dm_q == MD_REG) begin
                        dval_q  <= rf_rdata;
                        dloc_q  <= LOC_REG;
                        daddr_q <= DW'(df_q[RAW-1:0]);
                    end else begin
                        dval_q  <= df_q;
                    end
                end
                S_DST_WAIT: begin
                    if (mem_ack) dval_q <= mem_rdata;
                end
                S_FIN, S_BAD: ;
                default: ;
            endcase
        end
    end

    always_comb begin
        ready       = (state == S_IDLE);
        res_valid   = (state == S_FIN) || (state == S_BAD);
        res_illegal = (state == S_BAD);
        mem_req     = 1'b0;
        mem_addr    = '0;
        src_value   = sval_q;
        dst_value   = dval_q;
        wb0_kind    = LOC_NONE;
        wb0_addr    = '0;
        wb1_kind    = LOC_NONE;
        wb1_addr    = '0;
        unique case (state)
            S_SRC_WAIT: begin
                mem_req  = 1'b1;
                mem_addr = saddr_q;
            end
            S_DST_WAIT: begin
                mem_req  = 1'b1;
                mem_addr = daddr_q;
            end
            S_FIN: begin
                if (cls_q == CL_BIN || cls_q == CL_SWAP) begin
                    wb0_kind = dloc_q;
                    wb0_addr = daddr_q;
                end
                if (cls_q == CL_SWAP) begin
                    wb1_kind = sloc_q;
                    wb1_addr = saddr_q;
                end
                if (cls_q == CL_MOD) begin
                    wb0_kind = sloc_q;
                    wb0_addr = saddr_q;
                end
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/opr_checker.sv
module opr_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        start,
    input logic        ready,
    input logic [2:0]  op_class,
    input logic [1:0]  src_mode,
    input logic [1:0]  dst_mode,
    input logic        mem_req,
    input logic        mem_ack,
    input logic [15:0] mem_addr,
    input logic        res_valid,
    input logic        res_illegal,
    input logic [1:0]  wb0_kind,
    input logic [1:0]  wb1_kind
);
    logic       bad_combo;
    logic [2:0] cls_seen;

    assign bad_combo = (op_class > 3'd4)
                    || (op_class == 3'd0 && dst_mode == 2'b01)
                    || (op_class == 3'd1 && (src_mode == 2'b01 || dst_mode == 2'b01))
                    || (op_class == 3'd2 && src_mode == 2'b01);

    always_ff @(posedge clk) begin
        if (!rst_n)             cls_seen <= 3'd0;
        else if (start && ready) cls_seen <= op_class;
    end

    p_req_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_ack |=> mem_req && $stable(mem_addr));

    p_no_valid_in_read_r3: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> !res_valid);

    p_pulse_r12: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |=> !res_valid && ready);

    p_illegal_fast_r9: assert property (@(posedge clk) disable iff (!rst_n)
        start && ready && bad_combo |=> res_valid && res_illegal);

    p_illegal_clean_r9: assert property (@(posedge clk) disable iff (!rst_n)
        res_illegal |-> wb0_kind == 2'b00 && wb1_kind == 2'b00 && !mem_req);

    p_flow_no_target_r8: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid && cls_seen == 3'd3 |-> wb0_kind == 2'b00 && wb1_kind == 2'b00);

    p_none_fast_r11: assert property (@(posedge clk) disable iff (!rst_n)
        start && ready && op_class == 3'd4 |=> res_valid && !res_illegal);
endmodule

bind operand_resolver opr_checker u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (start),
    .ready       (ready),
    .op_class    (op_class),
    .src_mode    (src_mode),
    .dst_mode    (dst_mode),
    .mem_req     (mem_req),
    .mem_ack     (mem_ack),
    .mem_addr    (mem_addr),
    .res_valid   (res_valid),
    .res_illegal (res_illegal),
    .wb0_kind    (wb0_kind),
    .wb1_kind    (wb1_kind)
);

// File: tb/sim_operand_resolver.sv
`timescale 1ns/1ps
module sim_operand_resolver;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [2:0]  op_class = '0;
    logic [1:0]  src_mode = '0, dst_mode = '0;
    logic [15:0] src_field = '0, dst_field = '0;
    logic        ready;
    logic [3:0]  rf_raddr;
    logic [15:0] rf_rdata;
    logic        mem_req;
    logic [15:0] mem_addr;
    logic        mem_ack = 1'b0;
    logic [15:0] mem_rdata = '0;
    logic        res_valid, res_illegal;
    logic [15:0] src_value, dst_value, wb0_addr, wb1_addr;
    logic [1:0]  wb0_kind, wb1_kind;

    int n_chk = 0, n_bad = 0;
    int cyc = 0;
    logic [15:0] ref_val = 16'h0000;
    int mem_lat = 0;
    int mem_n = 0;
    logic [15:0] mem_log [0:3];
    int ncyc;
    logic pulse_ok;
    logic [15:0] g_sv, g_dv, g_w0a, g_w1a;
    logic [1:0]  g_w0k, g_w1k;
    logic        g_ill;

    always #5 clk = ~clk;

    operand_resolver u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .op_class(op_class),
        .src_mode(src_mode), .dst_mode(dst_mode), .src_field(src_field),
        .dst_field(dst_field), .ready(ready), .rf_raddr(rf_raddr),
        .rf_rdata(rf_rdata), .mem_req(mem_req), .mem_addr(mem_addr),
        .mem_ack(mem_ack), .mem_rdata(mem_rdata), .res_valid(res_valid),
        .res_illegal(res_illegal), .src_value(src_value), .dst_value(dst_value),
        .wb0_kind(wb0_kind), .wb0_addr(wb0_addr), .wb1_kind(wb1_kind),
        .wb1_addr(wb1_addr)
    );

    function automatic logic [15:0] rf_word(input logic [3:0] i);
        return (i == 4'd15) ? ref_val : 16'h1111 * {12'd0, i};
    endfunction

    function automatic logic [15:0] mem_word(input logic [15:0] a);
        return a ^ 16'h5A3C;
    endfunction

    assign rf_rdata = rf_word(rf_raddr);

    // memory model: acknowledge after mem_lat waiting cycles, log served addresses
    initial begin
        int wait_n;
        wait_n = 0;
        forever begin
            @(negedge clk);
            if (mem_req && !mem_ack) begin
                if (wait_n >= mem_lat) begin
                    mem_ack   = 1'b1;
                    mem_rdata = mem_word(mem_addr);
                    if (mem_n < 4) mem_log[mem_n] = mem_addr;
                    mem_n++;
                    wait_n = 0;
                end else begin
                    wait_n++;
                end
            end else begin
                mem_ack = 1'b0;
            end
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            n_bad++;
            $display("FAIL watchdog: expired, got %0d cycles, expected fewer", cyc);
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    task automatic chk(input logic ok, input string req, input logic [15:0] got, input logic [15:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic run_op(input logic [2:0] c, input logic [1:0] sm, input logic [1:0] dm,
                          input logic [15:0] sf, input logic [15:0] df);
        @(negedge clk);
        while (!ready) @(negedge clk);
        op_class = c; src_mode = sm; dst_mode = dm; src_field = sf; dst_field = df;
        start = 1'b1; mem_n = 0;
        @(negedge clk);
        start = 1'b0;
        ncyc = 1;
        while (!res_valid && ncyc < 200) begin
            @(negedge clk);
            ncyc++;
        end
        g_sv = src_value; g_dv = dst_value; g_ill = res_illegal;
        g_w0k = wb0_kind; g_w0a = wb0_addr; g_w1k = wb1_kind; g_w1a = wb1_addr;
        @(negedge clk);
        pulse_ok = !res_valid && ready;
        chk(pulse_ok, "R12 pulse then ready", {15'd0, res_valid}, 16'd0);
    endtask

    task automatic t_reset();
        chk(ready == 1'b1, "R1 ready", {15'd0, ready}, 16'd1);
        chk(res_valid == 1'b0, "R1 res_valid", {15'd0, res_valid}, 16'd0);
        chk(mem_req == 1'b0, "R1 mem_req", {15'd0, mem_req}, 16'd0);
    endtask

    task automatic t_reg_lit();
        run_op(3'd0, 2'b01, 2'b00, 16'h1234, 16'h0005);
        chk(g_ill == 1'b0, "R2 legal", {15'd0, g_ill}, 16'd0);
        chk(g_sv == 16'h1234, "R2 literal value", g_sv, 16'h1234);
        chk(g_dv == 16'h5555, "R2 register value", g_dv, 16'h5555);
        chk(g_w0k == 2'b01 && g_w0a == 16'd5, "R2 register target", g_w0a, 16'd5);
        chk(g_w1k == 2'b00, "R5 no second target", {14'd0, g_w1k}, 16'd0);
        chk(mem_n == 0, "R2 no RAM access", 16'(mem_n), 16'd0);
    endtask

    task automatic t_absolute();
        mem_lat = 3;
        run_op(3'd0, 2'b10, 2'b00, 16'h0400, 16'h0002);
        chk(g_sv == mem_word(16'h0400), "R3 absolute value", g_sv, mem_word(16'h0400));
        chk(mem_n == 1 && mem_log[0] == 16'h0400, "R3 absolute address", mem_log[0], 16'h0400);
        chk(g_dv == 16'h2222, "R3 dest register", g_dv, 16'h2222);
        mem_lat = 0;
    endtask

    task automatic t_indirect_wrap();
        ref_val = 16'hFFF0;
        mem_lat = 2;
        run_op(3'd0, 2'b11, 2'b11, 16'h0025, 16'h0010);
        chk(mem_n == 2, "R10 two reads", 16'(mem_n), 16'd2);
        chk(mem_log[0] == 16'h0015, "R4 R10 source first, wrapped", mem_log[0], 16'h0015);
        chk(mem_log[1] == 16'h0000, "R4 R10 dest second, wrapped", mem_log[1], 16'h0000);
        chk(g_sv == mem_word(16'h0015), "R4 source value", g_sv, mem_word(16'h0015));
        chk(g_dv == mem_word(16'h0000), "R4 dest value", g_dv, mem_word(16'h0000));
        chk(g_w0k == 2'b10 && g_w0a == 16'h0000, "R4 RAM target", g_w0a, 16'h0000);
        mem_lat = 0;
    endtask

    task automatic t_dest_literal();
        run_op(3'd0, 2'b10, 2'b01, 16'h0300, 16'h0007);
        chk(g_ill == 1'b1, "R5 literal dest illegal", {15'd0, g_ill}, 16'd1);
        chk(ncyc == 1, "R9 illegal next cycle", 16'(ncyc), 16'd1);
        chk(mem_n == 0, "R9 no request", 16'(mem_n), 16'd0);
        chk(g_w0k == 2'b00 && g_w1k == 2'b00, "R9 no target", {14'd0, g_w0k}, 16'd0);
    endtask

    task automatic t_swap();
        run_op(3'd1, 2'b00, 2'b10, 16'h0003, 16'h0200);
        chk(g_ill == 1'b0, "R6 swap legal", {15'd0, g_ill}, 16'd0);
        chk(g_w0k == 2'b10 && g_w0a == 16'h0200, "R6 wb0 dest", g_w0a, 16'h0200);
        chk(g_w1k == 2'b01 && g_w1a == 16'h0003, "R6 wb1 source", g_w1a, 16'h0003);
        chk(g_sv == 16'h3333 && g_dv == mem_word(16'h0200), "R6 values", g_dv, mem_word(16'h0200));
        run_op(3'd1, 2'b01, 2'b10, 16'h0003, 16'h0200);
        chk(g_ill == 1'b1 && mem_n == 0, "R6 literal source illegal", {15'd0, g_ill}, 16'd1);
    endtask

    task automatic t_modify();
        ref_val = 16'h1000;
        run_op(3'd2, 2'b11, 2'b01, 16'h0004, 16'h0000);
        chk(g_ill == 1'b0, "R7 modify legal", {15'd0, g_ill}, 16'd0);
        chk(g_w0k == 2'b10 && g_w0a == 16'h1004, "R7 operand target", g_w0a, 16'h1004);
        chk(g_sv == mem_word(16'h1004), "R7 operand value", g_sv, mem_word(16'h1004));
        chk(g_w1k == 2'b00, "R7 no second target", {14'd0, g_w1k}, 16'd0);
        run_op(3'd2, 2'b01, 2'b00, 16'h0004, 16'h0000);
        chk(g_ill == 1'b1, "R7 literal illegal", {15'd0, g_ill}, 16'd1);
    endtask

    task automatic t_flow();
        ref_val = 16'h2000;
        for (int m = 0; m < 4; m++) begin
            logic [15:0] e;
            run_op(3'd3, 2'(m), 2'b01, 16'h0006, 16'hFFFF);
            case (m)
                0: e = 16'h6666;
                1: e = 16'h0006;
                2: e = mem_word(16'h0006);
                default: e = mem_word(16'h2006);
            endcase
            chk(g_ill == 1'b0, "R8 flow legal", {15'd0, g_ill}, 16'd0);
            chk(g_sv == e, "R8 flow value", g_sv, e);
            chk(g_w0k == 2'b00 && g_w1k == 2'b00, "R8 no target", {14'd0, g_w0k}, 16'd0);
        end
    endtask

    task automatic t_classes();
        run_op(3'd4, 2'b10, 2'b10, 16'h0100, 16'h0200);
        chk(g_ill == 1'b0 && ncyc == 1, "R11 no-operand class", 16'(ncyc), 16'd1);
        chk(mem_n == 0 && g_w0k == 2'b00, "R11 no access", 16'(mem_n), 16'd0);
        for (int c = 5; c < 8; c++) begin
            run_op(3'(c), 2'b00, 2'b00, 16'h0001, 16'h0002);
            chk(g_ill == 1'b1, "R11 reserved class illegal", {15'd0, g_ill}, 16'd1);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_reg_lit();
        t_absolute();
        t_indirect_wrap();
        t_dest_literal();
        t_swap();
        t_modify();
        t_flow();
        t_classes();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule